// File: doc/BRIEF.md
# Channel Gate Latch with Thermal and Open-Load Flags

This block decides whether one low-side power switch is driven, and keeps the two diagnostic flags for that switch. A system with several switches places one copy per channel. Each copy takes these inputs:

- the channel's logic control level;
- the digital results of an over-temperature comparator and an open-load comparator;
- an active-low reset;
- a supply-good indication.

Every asynchronous input is brought onto the system clock before it is used.

The two faults behave differently.

- **Thermal fault:** it switches the output off and holds it off. A rising edge of the control input releases it.
- **Open-load fault:** it is only a report. It is sampled while the control input is low. A falling edge of the control input clears it, so detection starts again in each off period. It never touches the gate.

Reset clears both flags and holds the gate off. A low supply-good input holds the gate off for as long as it lasts, and leaves the flags unchanged. Current limiting is handled outside this block and creates no flag here.

Top module: `chan_fault_ctl`

## Requirements
- R1: While rst_n is low, gate_en, ot_flag and ol_flag are all 0, from the moment rst_n falls.
- R2: With no thermal flag set and pwr_ok high, gate_en equals ctl_in delayed by SYNC_STAGES+1 rising clock edges (3 with the default).
- R3: While the synchronized ot_cmp is 1, ot_flag is 1 and gate_en is 0, whatever the level of ctl_in.
- R4: Once set, ot_flag stays 1 and gate_en stays 0 after ot_cmp returns to 0, until the next rising edge of the synchronized ctl_in. That edge clears ot_flag, and gate_en follows ctl_in again.
- R5: If ot_cmp is still 1 when ctl_in rises, ot_flag stays 1 and gate_en stays 0.
- R6: ol_flag is set only when the synchronized ol_cmp is 1 while the synchronized ctl_in is 0. ol_cmp has no effect while ctl_in is 1.
- R7: ol_flag stays set through the following on period. It clears on the next falling edge of ctl_in, unless ol_cmp is 1 in that cycle.
- R8: ol_flag and ol_cmp never change gate_en.
- R9: While the synchronized pwr_ok is 0, gate_en is 0. The flags are not changed, and gate_en resumes following ctl_in once pwr_ok returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears flags and gate asynchronously |
| pwr_ok | input | 1 | Supply above the power-on threshold when 1 (asynchronous) |
| ctl_in | input | 1 | Channel control level, 1 = switch on (asynchronous) |
| ot_cmp | input | 1 | Over-temperature comparator result, 1 = too hot (asynchronous) |
| ol_cmp | input | 1 | Open-load comparator result, 1 = load impedance too high (asynchronous) |
| gate_en | output | 1 | Gate drive enable for the output switch |
| ot_flag | output | 1 | Over-temperature status bit |
| ol_flag | output | 1 | Open-load status bit |

## Verification
A wrong internal state shows up at the ports within one clock after the synchronizers deliver the causing input, so at most SYNC_STAGES+1 edges after the stimulus:

- a thermal latch that is stuck or cleared too early shows as gate_en driving while ot_flag is set, or as gate_en staying low after a clean rising edge;
- an edge detector that takes the wrong edge shows as ol_flag clearing on the rising edge instead of the falling one, or as ot_flag clearing on the falling edge.

The bench therefore samples each outcome exactly at the computed latency. It also holds each state across several extra cycles to catch flags that decay or clear when they should not.

// File: rtl/chan_fault_ctl.sv
module chan_fault_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  input  logic ctl_in,
  input  logic ot_cmp,
  input  logic ol_cmp,
  output logic gate_en,
  output logic ot_flag,
  output logic ol_flag
);

  localparam int NSIG = 4;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] stage [SYNC_STAGES];

  assign raw = {pwr_ok, ol_cmp, ot_cmp, ctl_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= raw;

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stage[i] <= '0;
      else        stage[i] <= stage[i-1];
  end

  logic ctl_s, ot_s, ol_s, pwr_s;
  assign ctl_s = stage[LAST][0];
  assign ot_s  = stage[LAST][1];
  assign ol_s  = stage[LAST][2];
  assign pwr_s = stage[LAST][3];

  logic ctl_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_d <= 1'b0;
    else        ctl_d <= ctl_s;

  logic rise, fall;
  assign rise = ctl_s & ~ctl_d;
  assign fall = ~ctl_s & ctl_d;

  // set wins over an edge clear in the same cycle
  logic ot_next, ol_next;
  assign ot_next = ot_s | (ot_flag & ~rise);
  assign ol_next = (ol_s & ~ctl_s) | (ol_flag & ~fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ot_flag <= 1'b0;
      ol_flag <= 1'b0;
      gate_en <= 1'b0;
    end else begin
      ot_flag <= ot_next;
      ol_flag <= ol_next;
      gate_en <= ctl_s & pwr_s & ~ot_next;
    end

endmodule

module chan_fault_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic ctl_s,
  input logic ctl_d,
  input logic ot_s,
  input logic pwr_s,
  input logic gate_en,
  input logic ot_flag,
  input logic ol_flag
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |-> (!gate_en && !ot_flag && !ol_flag));

  p_gate_needs_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> $past(ctl_s));

  p_thermal_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ot_s |=> (ot_flag && !gate_en));

  p_thermal_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> !gate_en);

  p_thermal_clear_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ot_flag) |-> $past(ctl_s && !ctl_d));

  p_open_set_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ol_flag) |-> $past(!ctl_s));

  p_open_clear_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ol_flag) |-> $past(!ctl_s && ctl_d));

  p_supply_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> !gate_en);

endmodule

bind chan_fault_ctl chan_fault_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_s(ctl_s), .ctl_d(ctl_d), .ot_s(ot_s),
  .pwr_s(pwr_s), .gate_en(gate_en), .ot_flag(ot_flag), .ol_flag(ol_flag)
);

// File: tb/chan_fault_ctl_test.sv
module chan_fault_ctl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0, ctl_in = 1'b0, ot_cmp = 1'b0, ol_cmp = 1'b0;
  logic gate_en, ot_flag, ol_flag;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  localparam int LAT = 3;

  always #2.5 clk = ~clk;

  chan_fault_ctl #(.SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ctl_in(ctl_in),
    .ot_cmp(ot_cmp), .ol_cmp(ol_cmp),
    .gate_en(gate_en), .ot_flag(ot_flag), .ol_flag(ol_flag)
  );

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] act;
    act = {gate_en, ot_flag, ol_flag};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {gate,ot,ol} actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    wait_n(2);
    chk("R1 during reset", 3'b000);
    pwr_ok = 1'b1; ctl_in = 1'b1;
    wait_n(2);
    chk("R1 held with ctl high", 3'b000);
    rst_n = 1'b1;
    wait_n(LAT + 1);
    chk("R2 after release", 3'b100);
  endtask

  task automatic t_follow;
    ctl_in = 1'b0;
    wait_n(LAT - 1);
    chk("R2 before latency", 3'b100);
    wait_n(1);
    chk("R2 at latency", 3'b000);
    ctl_in = 1'b1;
    wait_n(LAT - 1);
    chk("R2 rise before latency", 3'b000);
    wait_n(1);
    chk("R2 rise at latency", 3'b100);
  endtask

  task automatic t_thermal;
    ot_cmp = 1'b1;
    wait_n(LAT);
    chk("R3 trip with ctl high", 3'b010);
    wait_n(3);
    ot_cmp = 1'b0;
    wait_n(6);
    chk("R4 latched after comparator clears", 3'b010);
    ctl_in = 1'b0;
    wait_n(LAT + 1);
    chk("R4 falling edge does not clear", 3'b010);
    ctl_in = 1'b1;
    wait_n(LAT);
    chk("R4 rising edge clears", 3'b100);
    ctl_in = 1'b0;
    ot_cmp = 1'b1;
    wait_n(LAT + 1);
    chk("R3 trip with ctl low", 3'b010);
  endtask

  task automatic t_priority;
    ctl_in = 1'b1;
    wait_n(LAT + 2);
    chk("R5 rise with fault present", 3'b010);
    ot_cmp = 1'b0;
    wait_n(LAT + 2);
    chk("R5 no later release without edge", 3'b010);
    ctl_in = 1'b0;
    wait_n(LAT + 1);
    ctl_in = 1'b1;
    wait_n(LAT + 1);
    chk("R4 clean edge releases", 3'b100);
  endtask

  task automatic t_openload;
    ol_cmp = 1'b1;
    wait_n(LAT + 3);
    chk("R6 ignored while on", 3'b100);
    ctl_in = 1'b0;
    wait_n(LAT + 1);
    chk("R6 set while off", 3'b001);
    ol_cmp = 1'b0;
    ctl_in = 1'b1;
    wait_n(LAT + 3);
    chk("R7 R8 kept through on period, gate driven", 3'b101);
    ctl_in = 1'b0;
    wait_n(LAT + 1);
    chk("R7 falling edge clears", 3'b000);
    ol_cmp = 1'b1;
    wait_n(LAT + 1);
    chk("R6 set again in off period", 3'b001);
    ctl_in = 1'b1;
    wait_n(LAT + 1);
    ctl_in = 1'b0;
    wait_n(LAT + 1);
    chk("R7 comparator held at falling edge keeps flag", 3'b001);
    ol_cmp = 1'b0;
    ctl_in = 1'b1;
    wait_n(LAT + 1);
    chk("R8 gate on with open-load flag", 3'b101);
  endtask

  task automatic t_supply;
    pwr_ok = 1'b0;
    wait_n(LAT);
    chk("R9 supply low forces off, flag kept", 3'b001);
    wait_n(4);
    chk("R9 stays off", 3'b001);
    pwr_ok = 1'b1;
    wait_n(LAT);
    chk("R9 resumes", 3'b101);
  endtask

  task automatic t_reset_mid;
    ot_cmp = 1'b1;
    wait_n(LAT + 1);
    chk("R3 trip before reset", 3'b011);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", 3'b000);
    ot_cmp = 1'b0;
    wait_n(3);
    chk("R1 held", 3'b000);
    rst_n = 1'b1;
    wait_n(LAT + 1);
    chk("R1 R2 restart follows ctl", 3'b100);
  endtask

  initial begin
    wait_n(1);
    t_reset();
    t_follow();
    t_thermal();
    t_priority();
    t_openload();
    t_supply();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule